// File: doc/BRIEF.md
# Serial Symbol Aligner with Sync-Word Lock

This block takes a single-lane serial bit stream, one bit per clock, that an LVDS pad has already sampled. The stream is made of 12-bit symbols. Each symbol is a start bit of value 1, then ten payload bits sent least significant bit first, then a stop bit of value 0. Start and stop bits are ordinary bits, so they cannot mark a symbol boundary by themselves. The block therefore first hunts for a configurable 10-bit sync word. It checks every bit position of a sliding 12-bit window. The first window whose payload equals the sync word and whose framing bits are correct fixes the symbol boundary.

Once locked, the block slices the stream into 12-bit symbols. It checks the framing bits of each symbol, strips them, and presents the 10 payload bits with a one-cycle valid strobe. A symbol with wrong framing is not delivered and raises a sticky error flag. Four bad symbols in a row drop lock and restart the hunt. All clocks come from one synchronous source, so the block does no phase tracking.

Top module: `sym_aligner`

## Requirements
- R1: While rst_n is low, locked, valid and framing_error are 0 and data is 0.
- R2: While not locked, valid stays 0, and a stream without a correctly framed sync symbol never sets locked.
- R3: A symbol whose payload equals sync_word but whose start bit is not 1, or whose stop bit is not 0, does not cause lock.
- R4: Lock is found at any of the 12 bit offsets. The sync symbol itself is delivered as the first word, and locked and valid both rise in the cycle after its stop bit is sampled.
- R5: While locked, each following 12-bit symbol with correct framing gives exactly one valid pulse, one cycle after its stop bit. data carries payload bit 0 as the first payload bit received after the start bit.
- R6: While locked, a symbol with start bit 0 or stop bit 1 is not delivered and sets framing_error. Framing is not judged while hunting.
- R7: Fewer than four consecutive bad symbols keep lock, and a good symbol restarts the count of consecutive bad symbols.
- R8: The fourth consecutive bad symbol drops locked in the cycle after its last bit, and the hunt then restarts.
- R9: A 1 on err_clr clears framing_error unless a new framing error is flagged in the same cycle.
- R10: sync_word is read live while hunting. After it changes, only the new value can cause lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_in | input | 1 | Serial bit, sampled on each rising edge |
| sync_word | input | 10 | Payload value that marks the symbol boundary |
| err_clr | input | 1 | Write-one-to-clear for framing_error |
| data | output | 10 | Payload of the last delivered symbol |
| valid | output | 1 | One-cycle strobe per delivered symbol |
| locked | output | 1 | Symbol boundary is fixed |
| framing_error | output | 1 | Sticky flag for a bad framing bit seen while locked |

## Verification
The hardest case to reach is a false lock. Sync-like bit patterns can straddle the leading zeros, a symbol with bad framing and the zeros that follow it. The stimulus picks sync words and fill patterns so that a shifted window either must not match or must match only at the intended offset. It then shows that locked stays low across payload-matching symbols with a bad start or a bad stop bit. Loss of lock is reached only by an exact run of four bad symbols, after two runs of three separated by good symbols.

// File: rtl/sym_aligner_pkg.sv
package sym_aligner_pkg;
  typedef enum logic [0:0] {
    MODE_HUNT  = 1'b0,
    MODE_TRACK = 1'b1
  } align_mode_e;
endpackage

// File: rtl/sym_shift_window.sv
module sym_shift_window #(
  parameter int SYM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_in,
  output logic [SYM_W-1:0] win,
  output logic             full
);
  localparam int FILL_W = $clog2(SYM_W + 1);

  logic [SYM_W-1:0]  win_q, win_d;
  logic [FILL_W-1:0] fill_q, fill_d;
  logic              fill_en;

  // newest bit enters at the top, the oldest sits at bit 0
  always_comb begin
    win_d   = {bit_in, win_q[SYM_W-1:1]};
    fill_en = (fill_q != FILL_W'(SYM_W));
    fill_d  = fill_q + FILL_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      fill_q <= '0;
    end else begin
      win_q <= win_d;
      if (fill_en) fill_q <= fill_d;
    end
  end

  assign win  = win_q;
  assign full = (fill_q == FILL_W'(SYM_W));

  // R4
  window_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> full);
endmodule

// File: rtl/sym_frame_check.sv
module sym_frame_check #(
  parameter int   PAYLOAD_W = 10,
  parameter logic START_VAL = 1'b1,
  parameter logic STOP_VAL  = 1'b0,
  localparam int  SYM_W     = PAYLOAD_W + 2
) (
  input  logic [SYM_W-1:0]     win,
  input  logic [PAYLOAD_W-1:0] sync_word,
  output logic [PAYLOAD_W-1:0] payload,
  output logic                 frame_ok,
  output logic                 sync_hit
);
  // payload bit i was the (i+1)-th bit after the start bit
  for (genvar i = 0; i < PAYLOAD_W; i++) begin : g_pay
    assign payload[i] = win[i+1];
  end

  always_comb begin
    frame_ok = (win[0] == START_VAL) && (win[SYM_W-1] == STOP_VAL);
    sync_hit = (payload == sync_word);
  end
endmodule

// File: rtl/sym_lock_ctrl.sv
module sym_lock_ctrl
  import sym_aligner_pkg::*;
#(
  parameter int SYM_W      = 12,
  parameter int LOSS_LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic full,
  input  logic frame_ok,
  input  logic sync_hit,
  output logic locked,
  output logic take,
  output logic frame_bad
);
  localparam int PH_W   = $clog2(SYM_W + 1);
  localparam int MISS_W = $clog2(LOSS_LIMIT + 1);

  align_mode_e       mode_q, mode_d;
  logic [PH_W-1:0]   phase_q, phase_d;
  logic [MISS_W-1:0] miss_q, miss_d;
  logic              boundary;

  always_comb begin
    mode_d    = mode_q;
    phase_d   = phase_q;
    miss_d    = miss_q;
    take      = 1'b0;
    frame_bad = 1'b0;
    boundary  = (phase_q == PH_W'(SYM_W));
    case (mode_q)
      MODE_HUNT: begin
        if (full && frame_ok && sync_hit) begin
          mode_d  = MODE_TRACK;
          take    = 1'b1;
          phase_d = PH_W'(1);
          miss_d  = '0;
        end
      end
      MODE_TRACK: begin
        if (boundary) begin
          phase_d = PH_W'(1);
          if (frame_ok) begin
            take   = 1'b1;
            miss_d = '0;
          end else begin
            frame_bad = 1'b1;
            if (miss_q == MISS_W'(LOSS_LIMIT - 1)) begin
              mode_d = MODE_HUNT;
              miss_d = '0;
            end else begin
              miss_d = miss_q + MISS_W'(1);
            end
          end
        end else begin
          phase_d = phase_q + PH_W'(1);
        end
      end
      default: mode_d = MODE_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_HUNT;
      phase_q <= '0;
      miss_q  <= '0;
    end else begin
      mode_q  <= mode_d;
      phase_q <= phase_d;
      miss_q  <= miss_d;
    end
  end

  assign locked = (mode_q == MODE_TRACK);

  // R5
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (phase_q >= PH_W'(1) && phase_q <= PH_W'(SYM_W)));
  // R8
  miss_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_q < MISS_W'(LOSS_LIMIT));
  // R3
  hunt_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && take) |-> (frame_ok && sync_hit));
endmodule

// File: rtl/sym_aligner.sv
module sym_aligner #(
  parameter int   PAYLOAD_W  = 10,
  parameter int   LOSS_LIMIT = 4,
  parameter logic START_VAL  = 1'b1,
  parameter logic STOP_VAL   = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_in,
  input  logic [PAYLOAD_W-1:0] sync_word,
  input  logic                 err_clr,
  output logic [PAYLOAD_W-1:0] data,
  output logic                 valid,
  output logic                 locked,
  output logic                 framing_error
);
  localparam int SYM_W = PAYLOAD_W + 2;

  logic [SYM_W-1:0]     win;
  logic                 full;
  logic [PAYLOAD_W-1:0] payload;
  logic                 frame_ok, sync_hit;
  logic                 take, frame_bad;

  logic [PAYLOAD_W-1:0] data_q;
  logic                 valid_q, valid_d;
  logic                 ferr_q, ferr_d;

  sym_shift_window #(.SYM_W(SYM_W)) u_win (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .win(win), .full(full)
  );

  sym_frame_check #(
    .PAYLOAD_W(PAYLOAD_W), .START_VAL(START_VAL), .STOP_VAL(STOP_VAL)
  ) u_chk (
    .win(win), .sync_word(sync_word), .payload(payload),
    .frame_ok(frame_ok), .sync_hit(sync_hit)
  );

  sym_lock_ctrl #(.SYM_W(SYM_W), .LOSS_LIMIT(LOSS_LIMIT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .full(full), .frame_ok(frame_ok),
    .sync_hit(sync_hit), .locked(locked), .take(take), .frame_bad(frame_bad)
  );

  // a new error wins over a clear in the same cycle
  always_comb begin
    valid_d = take;
    ferr_d  = ferr_q;
    if (err_clr)   ferr_d = 1'b0;
    if (frame_bad) ferr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      if (take) data_q <= payload;
      valid_q <= valid_d;
      ferr_q  <= ferr_d;
    end
  end

  assign data          = data_q;
  assign valid         = valid_q;
  assign framing_error = ferr_q;

  // R2
  valid_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> locked);
  // R5
  valid_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  // R6
  ferr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_bad |=> framing_error);
  // R8
  drop_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> framing_error);
endmodule

// File: tb/sym_aligner_test.sv
module sym_aligner_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_in = 1'b0;
  logic [9:0] sync_word = 10'h3FF;
  logic       err_clr = 1'b0;
  logic [9:0] data;
  logic       valid, locked, framing_error;

  int checks = 0;
  int errors = 0;
  logic [9:0] exp_q[$];

  always #2.5 clk = ~clk;

  sym_aligner uut (
    .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .sync_word(sync_word),
    .err_clr(err_clr), .data(data), .valid(valid), .locked(locked),
    .framing_error(framing_error)
  );

  task automatic chk(input string req, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each valid strobe
  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (exp_q.size() == 0) begin
        chk("R2 unexpected word", data, 10'h000);
        if (data === 10'h000) begin
          errors++;
          $display("FAIL R2 valid with empty queue actual=%h expected=none", data);
        end
      end else begin
        chk("R5 word", data, exp_q.pop_front());
      end
    end
  end

  task automatic drive_bit(input logic b);
    @(negedge clk);
    bit_in = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive_bit(1'b0);
  endtask

  task automatic send_sym(input logic [9:0] p, input logic st, input logic sp, input bit deliver);
    if (deliver) exp_q.push_back(p);
    drive_bit(st);
    for (int i = 0; i < 10; i++) drive_bit(p[i]);
    drive_bit(sp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bit_in = 1'b0;
    exp_q.delete();
    repeat (3) @(negedge clk);
    chk("R1 locked", {9'd0, locked}, 10'd0);
    chk("R1 valid", {9'd0, valid}, 10'd0);
    chk("R1 ferr", {9'd0, framing_error}, 10'd0);
    chk("R1 data", data, 10'd0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R2 and R3: no lock without a correctly framed sync symbol
    do_reset();
    sync_word = 10'h001;
    idle(40);
    for (int i = 0; i < 4; i++) send_sym(10'h000, 1'b1, 1'b0, 0);
    idle(14);
    chk("R2 no lock on framed data", {9'd0, locked}, 10'd0);
    chk("R6 no framing error while hunting", {9'd0, framing_error}, 10'd0);
    send_sym(10'h001, 1'b1, 1'b1, 0);
    idle(14);
    chk("R3 bad stop no lock", {9'd0, locked}, 10'd0);
    send_sym(10'h001, 1'b0, 1'b0, 0);
    idle(14);
    chk("R3 bad start no lock", {9'd0, locked}, 10'd0);
    send_sym(10'h001, 1'b1, 1'b0, 1);
    send_sym(10'h2B4, 1'b1, 1'b0, 1);
    idle(3);
    chk("R4 lock after good sync", {9'd0, locked}, 10'd1);
    chk("R5 queue drained", 10'(exp_q.size()), 10'd0);

    // R4: every bit offset
    for (int k = 0; k < 12; k++) begin
      do_reset();
      sync_word = 10'h3FF;
      idle(12 + k);
      send_sym(10'h3FF, 1'b1, 1'b0, 1);
      send_sym(10'((k * 37 + 5) & 10'h3FF), 1'b1, 1'b0, 1);
      send_sym(10'h155 ^ 10'(k), 1'b1, 1'b0, 1);
      idle(3);
      chk("R4 locked at offset", {9'd0, locked}, 10'd1);
      chk("R4 words at offset", 10'(exp_q.size()), 10'd0);
    end

    // R6, R7, R8, R9, R10
    do_reset();
    sync_word = 10'h3FF;
    idle(14);
    send_sym(10'h3FF, 1'b1, 1'b0, 1);
    send_sym(10'h0A1, 1'b1, 1'b0, 1);
    send_sym(10'h155, 1'b1, 1'b1, 0);
    send_sym(10'h1C3, 1'b1, 1'b0, 1);
    chk("R6 sticky after bad stop", {9'd0, framing_error}, 10'd1);
    for (int i = 0; i < 3; i++) send_sym(10'h000, 1'b0, 1'b0, 0);
    send_sym(10'h2E7, 1'b1, 1'b0, 1);
    chk("R7 lock held after three bad", {9'd0, locked}, 10'd1);
    for (int i = 0; i < 3; i++) send_sym(10'h000, 1'b0, 1'b0, 0);
    send_sym(10'h019, 1'b1, 1'b0, 1);
    chk("R7 run restarted by good symbol", {9'd0, locked}, 10'd1);
    for (int i = 0; i < 4; i++) send_sym(10'h000, 1'b0, 1'b0, 0);
    idle(2);
    chk("R8 lock dropped", {9'd0, locked}, 10'd0);
    chk("R6 flag still set", {9'd0, framing_error}, 10'd1);
    @(negedge clk); err_clr = 1'b1; bit_in = 1'b0;
    @(negedge clk); err_clr = 1'b0;
    idle(1);
    chk("R9 flag cleared", {9'd0, framing_error}, 10'd0);
    sync_word = 10'h2C7;
    idle(13);
    send_sym(10'h3FF, 1'b1, 1'b0, 0);
    idle(13);
    chk("R10 old sync ignored", {9'd0, locked}, 10'd0);
    send_sym(10'h2C7, 1'b1, 1'b0, 1);
    send_sym(10'h36A, 1'b1, 1'b0, 1);
    idle(3);
    chk("R8 relock after hunt", {9'd0, locked}, 10'd1);
    chk("R10 words after relock", 10'(exp_q.size()), 10'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule